// File: doc/BRIEF.md
# Complex Sign-LMS Fractionally Spaced Equalizer

This block is an adaptive FIR equalizer for complex baseband samples taken at twice the symbol rate. Each symbol it takes a pair of complex samples through a valid/ready handshake and pushes them into an eight-entry delay line. It then forms the complex filter output as the sum of each stored sample times its complex coefficient, using one complex multiply-accumulate per cycle, and presents the result with a one-cycle valid strobe.

A downstream decision stage returns a complex symbol error with a strobe. The block then walks the taps once and adds to every coefficient the error times the sign-conjugate of the stored sample, scaled by a power-of-two step. It saturates each sum to the coefficient width, and pulses done when the last tap has been written. The block accepts the next pair in that same cycle.

Samples and coefficients are signed fractions with the binary point just below the sign bit (a value of v counts as v/2^(W-1)). The output carries one more integer bit.

Top module: `ffe_cplx_slms`

## Requirements
- R1: After reset, in_ready_o is 1 and y_valid_o and done_o are 0. The delay line holds zeros. Every coefficient is zero except the real part of tap 0, which holds one half (2^(CW-2)). The first output therefore equals half of the sample written to position 0.
- R2: A pair is taken on a rising edge where in_valid_i and in_ready_o are both 1. in_ready_o then stays 0 until done_o. A pair offered while in_ready_o is 0 is not taken.
- R3: On acceptance, sample 0 (s0_*) enters position 0 and sample 1 (s1_*) enters position 1. Every older entry moves two positions toward position NTAPS-1, and the two oldest are dropped.
- R4: y is the complex sum over k of x[k]·c[k], arithmetic-shifted right by CW-1 (rounding toward minus infinity) and saturated to DW+1 signed bits. It appears with a one-cycle y_valid_o pulse on the 8th rising edge after the accepting edge, and holds until the next pulse.
- R5: The error is captured on a rising edge where err_valid_i is 1 while the block waits for it. That window starts in the cycle in which y_valid_o is 1. A strobe at any other time (during filtering, adaptation or idle) has no effect on any coefficient.
- R6: Each coefficient becomes c + ((e·sc(x)) >>> MU_SHIFT), applied to real and imaginary parts separately. Here sc(x) = sgn(Re x) − j·sgn(Im x), a zero part counts as positive, and x is the sample held at that tap during the symbol's filtering.
- R7: The coefficient update saturates to the signed CW-bit range instead of wrapping.
- R8: done_o pulses for one cycle on the 8th rising edge after the capturing edge, and in_ready_o is 1 in that same cycle.
- R9: When the error arrives in the y_valid_o cycle, one pair-accept to the next takes no more than 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair offered |
| in_ready_o | output | 1 | Block idle, pair can be taken |
| s0_re_i | input | DW | Sample 0, real part (to position 0) |
| s0_im_i | input | DW | Sample 0, imaginary part |
| s1_re_i | input | DW | Sample 1, real part (to position 1) |
| s1_im_i | input | DW | Sample 1, imaginary part |
| y_valid_o | output | 1 | Filter output strobe |
| y_re_o | output | DW+1 | Filter output, real part |
| y_im_o | output | DW+1 | Filter output, imaginary part |
| err_valid_i | input | 1 | Symbol error strobe |
| err_re_i | input | DW | Symbol error, real part |
| err_im_i | input | DW | Symbol error, imaginary part |
| done_o | output | 1 | Adaptation finished strobe |

## Verification
The output strobe and the error capture can share one cycle, because the error window opens in the very cycle that y_valid_o is high. The bench provokes this by returning the error at once in every third symbol, and a few cycles late in the other symbols. It judges the result by comparing each later output against an independent model of the coefficients, and by timing the spacing from one accept to the next. The bench also injects stray error strobes during filtering and adaptation. Any capture of those would show up as a miscompare in the next output.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
  localparam int unsigned FFE_TAPS     = 8;
  localparam int unsigned FFE_DW       = 10;
  localparam int unsigned FFE_CW       = 10;
  localparam int unsigned FFE_MU_SHIFT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILT,
    ST_WAIT,
    ST_ADAPT
  } ffe_state_e;
endpackage

// File: rtl/ffe_delay_line.sv
module ffe_delay_line #(
  parameter int unsigned NTAPS = 8,
  parameter int unsigned DW    = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [DW-1:0]              in0_re_i,
  input  logic [DW-1:0]              in0_im_i,
  input  logic [DW-1:0]              in1_re_i,
  input  logic [DW-1:0]              in1_im_i,
  output logic [NTAPS-1:0][DW-1:0]   re_o,
  output logic [NTAPS-1:0][DW-1:0]   im_o
);
  logic [DW-1:0] tap_re [NTAPS];
  logic [DW-1:0] tap_im [NTAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAPS; k++) begin
        tap_re[k] <= '0;
        tap_im[k] <= '0;
      end
    end else if (load_i) begin
      tap_re[0] <= in0_re_i;
      tap_im[0] <= in0_im_i;
      tap_re[1] <= in1_re_i;
      tap_im[1] <= in1_im_i;
      for (int k = 2; k < NTAPS; k++) begin
        tap_re[k] <= tap_re[k-2];
        tap_im[k] <= tap_im[k-2];
      end
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_out
    assign re_o[k] = tap_re[k];
    assign im_o[k] = tap_im[k];
  end
endmodule

// File: rtl/ffe_cmac.sv
module ffe_cmac #(
  parameter int unsigned DW = 10,
  parameter int unsigned CW = 10,
  parameter int unsigned AW = 24
) (
  input  logic signed [DW-1:0] x_re_i,
  input  logic signed [DW-1:0] x_im_i,
  input  logic signed [CW-1:0] c_re_i,
  input  logic signed [CW-1:0] c_im_i,
  input  logic signed [AW-1:0] acc_re_i,
  input  logic signed [AW-1:0] acc_im_i,
  output logic signed [AW-1:0] acc_re_o,
  output logic signed [AW-1:0] acc_im_o
);
  localparam int unsigned PW  = DW + CW;
  localparam int unsigned EXT = AW - PW;

  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [AW-1:0] w_rr, w_ii, w_ri, w_ir;

  assign p_rr = x_re_i * c_re_i;
  assign p_ii = x_im_i * c_im_i;
  assign p_ri = x_re_i * c_im_i;
  assign p_ir = x_im_i * c_re_i;

  assign w_rr = {{EXT{p_rr[PW-1]}}, p_rr};
  assign w_ii = {{EXT{p_ii[PW-1]}}, p_ii};
  assign w_ri = {{EXT{p_ri[PW-1]}}, p_ri};
  assign w_ir = {{EXT{p_ir[PW-1]}}, p_ir};

  assign acc_re_o = acc_re_i + w_rr - w_ii;
  assign acc_im_o = acc_im_i + w_ri + w_ir;
endmodule

// File: rtl/ffe_coef_upd.sv
module ffe_coef_upd #(
  parameter int unsigned DW = 10,
  parameter int unsigned CW = 10,
  parameter int unsigned MU = 8
) (
  input  logic signed [CW-1:0] c_re_i,
  input  logic signed [CW-1:0] c_im_i,
  input  logic                 x_re_neg_i,
  input  logic                 x_im_neg_i,
  input  logic signed [DW-1:0] e_re_i,
  input  logic signed [DW-1:0] e_im_i,
  output logic signed [CW-1:0] c_re_o,
  output logic signed [CW-1:0] c_im_o
);
  localparam int unsigned EW = DW + 2;
  localparam int unsigned SW = ((CW > EW) ? CW : EW) + 1;
  localparam logic signed [SW-1:0] C_HI = SW'(2**(CW-1) - 1);
  localparam logic signed [SW-1:0] C_LO = ~C_HI;

  logic signed [EW-1:0] er_x, ei_x, t_re, t_im, d_re, d_im;
  logic signed [SW-1:0] s_re, s_im;

  assign er_x = {{2{e_re_i[DW-1]}}, e_re_i};
  assign ei_x = {{2{e_im_i[DW-1]}}, e_im_i};

  // e * (sr - j si): real = er*sr + ei*si, imag = ei*sr - er*si
  assign t_re = (x_re_neg_i ? -er_x : er_x) + (x_im_neg_i ? -ei_x : ei_x);
  assign t_im = (x_re_neg_i ? -ei_x : ei_x) - (x_im_neg_i ? -er_x : er_x);

  assign d_re = t_re >>> MU;
  assign d_im = t_im >>> MU;

  assign s_re = {{(SW-CW){c_re_i[CW-1]}}, c_re_i} + {{(SW-EW){d_re[EW-1]}}, d_re};
  assign s_im = {{(SW-CW){c_im_i[CW-1]}}, c_im_i} + {{(SW-EW){d_im[EW-1]}}, d_im};

  always_comb begin
    if (s_re > C_HI)      c_re_o = C_HI[CW-1:0];
    else if (s_re < C_LO) c_re_o = C_LO[CW-1:0];
    else                  c_re_o = s_re[CW-1:0];
    if (s_im > C_HI)      c_im_o = C_HI[CW-1:0];
    else if (s_im < C_LO) c_im_o = C_LO[CW-1:0];
    else                  c_im_o = s_im[CW-1:0];
  end
endmodule

// File: rtl/ffe_cplx_slms.sv
module ffe_cplx_slms
  import ffe_pkg::*;
#(
  parameter int unsigned NTAPS    = FFE_TAPS,
  parameter int unsigned DW       = FFE_DW,
  parameter int unsigned CW       = FFE_CW,
  parameter int unsigned MU_SHIFT = FFE_MU_SHIFT,
  parameter int unsigned YW       = DW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] s0_re_i,
  input  logic signed [DW-1:0] s0_im_i,
  input  logic signed [DW-1:0] s1_re_i,
  input  logic signed [DW-1:0] s1_im_i,
  output logic                 y_valid_o,
  output logic signed [YW-1:0] y_re_o,
  output logic signed [YW-1:0] y_im_o,
  input  logic                 err_valid_i,
  input  logic signed [DW-1:0] err_re_i,
  input  logic signed [DW-1:0] err_im_i,
  output logic                 done_o
);
  localparam int unsigned IW = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam int unsigned AW = DW + CW + 1 + IW;
  localparam logic [IW-1:0] LAST = IW'(NTAPS - 1);
  localparam logic signed [CW-1:0] C_HALF = CW'(2**(CW-2));
  localparam logic signed [AW-1:0] Y_HI = AW'(2**(YW-1) - 1);
  localparam logic signed [AW-1:0] Y_LO = ~Y_HI;

  ffe_state_e state;
  logic [IW-1:0] idx;
  logic signed [AW-1:0] acc_re, acc_im, mac_re, mac_im, ysh_re, ysh_im;
  logic signed [CW-1:0] c_re [NTAPS];
  logic signed [CW-1:0] c_im [NTAPS];
  logic signed [CW-1:0] upd_re, upd_im;
  logic signed [DW-1:0] e_re, e_im;
  logic signed [DW-1:0] x_sel_re, x_sel_im;
  logic [NTAPS-1:0][DW-1:0] x_re, x_im;
  logic signed [YW-1:0] ysat_re, ysat_im;
  logic accept;

  assign in_ready_o = (state == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;

  ffe_delay_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .in0_re_i (s0_re_i),
    .in0_im_i (s0_im_i),
    .in1_re_i (s1_re_i),
    .in1_im_i (s1_im_i),
    .re_o     (x_re),
    .im_o     (x_im)
  );

  assign x_sel_re = x_re[idx];
  assign x_sel_im = x_im[idx];

  ffe_cmac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .x_re_i   (x_sel_re),
    .x_im_i   (x_sel_im),
    .c_re_i   (c_re[idx]),
    .c_im_i   (c_im[idx]),
    .acc_re_i (acc_re),
    .acc_im_i (acc_im),
    .acc_re_o (mac_re),
    .acc_im_o (mac_im)
  );

  ffe_coef_upd #(.DW(DW), .CW(CW), .MU(MU_SHIFT)) u_upd (
    .c_re_i     (c_re[idx]),
    .c_im_i     (c_im[idx]),
    .x_re_neg_i (x_sel_re[DW-1]),
    .x_im_neg_i (x_sel_im[DW-1]),
    .e_re_i     (e_re),
    .e_im_i     (e_im),
    .c_re_o     (upd_re),
    .c_im_o     (upd_im)
  );

  // scale back to sample units, then clamp to output width
  assign ysh_re = mac_re >>> (CW - 1);
  assign ysh_im = mac_im >>> (CW - 1);

  always_comb begin
    if (ysh_re > Y_HI)      ysat_re = Y_HI[YW-1:0];
    else if (ysh_re < Y_LO) ysat_re = Y_LO[YW-1:0];
    else                    ysat_re = ysh_re[YW-1:0];
    if (ysh_im > Y_HI)      ysat_im = Y_HI[YW-1:0];
    else if (ysh_im < Y_LO) ysat_im = Y_LO[YW-1:0];
    else                    ysat_im = ysh_im[YW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      idx       <= '0;
      acc_re    <= '0;
      acc_im    <= '0;
      e_re      <= '0;
      e_im      <= '0;
      y_re_o    <= '0;
      y_im_o    <= '0;
      y_valid_o <= 1'b0;
      done_o    <= 1'b0;
      for (int k = 0; k < NTAPS; k++) begin
        c_re[k] <= (k == 0) ? C_HALF : '0;
        c_im[k] <= '0;
      end
    end else begin
      y_valid_o <= 1'b0;
      done_o    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_FILT;
            idx    <= '0;
            acc_re <= '0;
            acc_im <= '0;
          end
        end
        ST_FILT: begin
          acc_re <= mac_re;
          acc_im <= mac_im;
          idx    <= idx + 1'b1;
          if (idx == LAST) begin
            state     <= ST_WAIT;
            idx       <= '0;
            y_re_o    <= ysat_re;
            y_im_o    <= ysat_im;
            y_valid_o <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (err_valid_i) begin
            e_re  <= err_re_i;
            e_im  <= err_im_i;
            idx   <= '0;
            state <= ST_ADAPT;
          end
        end
        ST_ADAPT: begin
          c_re[idx] <= upd_re;
          c_im[idx] <= upd_im;
          idx       <= idx + 1'b1;
          if (idx == LAST) begin
            state  <= ST_IDLE;
            idx    <= '0;
            done_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ffe_cplx_slms_chk.sv
module ffe_cplx_slms_chk #(
  parameter int unsigned NTAPS = 8,
  parameter int unsigned YW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          y_valid_o,
  input logic [YW-1:0] y_re_o,
  input logic [YW-1:0] y_im_o,
  input logic          err_valid_i,
  input logic          done_o
);
  localparam int unsigned CNTW = $clog2(NTAPS + 2) + 1;

  logic            run;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (in_valid_i && in_ready_o) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (y_valid_o) run <= 1'b0;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R2
  AST_READY_ONLY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> done_o); // R2
  AST_Y_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (run && cnt == CNTW'(NTAPS))); // R4
  AST_Y_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |=> !y_valid_o); // R4
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_valid_o |-> ($stable(y_re_o) && $stable(y_im_o))); // R4
  AST_Y_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> !in_ready_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o); // R8
endmodule

bind ffe_cplx_slms ffe_cplx_slms_chk #(.NTAPS(NTAPS), .YW(YW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .y_valid_o   (y_valid_o),
  .y_re_o      (y_re_o),
  .y_im_o      (y_im_o),
  .err_valid_i (err_valid_i),
  .done_o      (done_o)
);

// File: tb/sim_ffe_cplx_slms.sv
module sim_ffe_cplx_slms;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int DW = 10;
  localparam int CW = 10;
  localparam int MU = 8;
  localparam int YW = DW + 1;
  localparam int NVEC = 12;

  // s0_re, s0_im, s1_re, s1_im, e_re, e_im
  localparam int VEC [NVEC][6] = '{
    '{ 200, -100,   50,   30,   40,  -20},
    '{-300,  120,    0,   -7,  -90,   60},
    '{   0,    0,  511, -512,  300,  300},
    '{-512,  511,  100,  100, -511, -512},
    '{  77, -301,  -45,    0,   12,   -3},
    '{ 350,  350, -350, -350,    0,    0},
    '{  -1,    1,    1,   -1,  255, -255},
    '{ 480,  -20,  220,  410, -128,  400},
    '{-200, -200,  300, -100,  511,  511},
    '{  10,  500, -500,   10, -300,  150},
    '{ 128,   64,  -64, -128,   64,  -64},
    '{-450,   90,    0,    0,  200, -400}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] s0_re = '0, s0_im = '0, s1_re = '0, s1_im = '0;
  logic err_valid = 1'b0;
  logic signed [DW-1:0] err_re = '0, err_im = '0;
  logic in_ready, y_valid, done;
  logic signed [YW-1:0] y_re, y_im;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;

  int m_xr [NT], m_xi [NT], m_cr [NT], m_ci [NT];
  int exp_yr, exp_yi;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ffe_cplx_slms u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .s0_re_i     (s0_re),
    .s0_im_i     (s0_im),
    .s1_re_i     (s1_re),
    .s1_im_i     (s1_im),
    .y_valid_o   (y_valid),
    .y_re_o      (y_re),
    .y_im_o      (y_im),
    .err_valid_i (err_valid),
    .err_re_i    (err_re),
    .err_im_i    (err_im),
    .done_o      (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input longint v, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return int'(hi);
    if (v < -hi - 1) return int'(-hi - 1);
    return int'(v);
  endfunction

  task automatic m_reset();
    for (int k = 0; k < NT; k++) begin
      m_xr[k] = 0; m_xi[k] = 0; m_ci[k] = 0;
      m_cr[k] = (k == 0) ? (1 << (CW - 2)) : 0;
    end
  endtask

  task automatic m_insert(input int a, input int b, input int c, input int d);
    for (int k = NT - 1; k >= 2; k--) begin
      m_xr[k] = m_xr[k-2];
      m_xi[k] = m_xi[k-2];
    end
    m_xr[0] = a; m_xi[0] = b; m_xr[1] = c; m_xi[1] = d;
  endtask

  task automatic m_output();
    longint ar = 0, ai = 0;
    for (int k = 0; k < NT; k++) begin
      ar += longint'(m_xr[k]) * m_cr[k] - longint'(m_xi[k]) * m_ci[k];
      ai += longint'(m_xr[k]) * m_ci[k] + longint'(m_xi[k]) * m_cr[k];
    end
    exp_yr = sat(ar >>> (CW - 1), YW);
    exp_yi = sat(ai >>> (CW - 1), YW);
  endtask

  task automatic m_adapt(input int er, input int ei);
    for (int k = 0; k < NT; k++) begin
      int sr = (m_xr[k] >= 0) ? 1 : -1;
      int si = (m_xi[k] >= 0) ? 1 : -1;
      int tr = er * sr + ei * si;
      int ti = ei * sr - er * si;
      m_cr[k] = sat(longint'(m_cr[k] + (tr >>> MU)), CW);
      m_ci[k] = sat(longint'(m_ci[k] + (ti >>> MU)), CW);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; in_valid = 1'b0; err_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    m_reset();
  endtask

  // one full symbol: accept, output, error, adaptation
  task automatic run_sym(input int a, input int b, input int c, input int d,
                         input int er, input int ei, input int dly,
                         input bit stray, input bit hold, output longint period);
    longint t0;
    int k;
    bit busy_seen;
    busy_seen = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    s0_re = DW'(a); s0_im = DW'(b); s1_re = DW'(c); s1_im = DW'(d);
    k = 0;
    while (!in_ready && k < 64) begin @(negedge clk); k++; end
    t0 = cyc;
    @(negedge clk);
    if (hold) begin
      s0_re = -DW'(a) - 1; s0_im = 'sd5; s1_re = 'sd123; s1_im = -DW'(d) - 1;
    end else begin
      in_valid = 1'b0;
    end
    if (stray) begin
      err_valid = 1'b1; err_re = -512; err_im = -512;
    end
    m_insert(a, b, c, d);
    m_output();
    k = 1;
    while (!y_valid && k < 64) begin
      if (in_ready) busy_seen = 1'b1;
      @(negedge clk);
      err_valid = 1'b0;
      k++;
    end
    chk(k == 9, "R4", "output latency in negedges", k, 9);
    chk(y_re == exp_yr, "R4/R3/R6", "y_re", y_re, exp_yr);
    chk(y_im == exp_yi, "R4/R3/R6", "y_im", y_im, exp_yi);
    if (dly > 0) repeat (dly) @(negedge clk);
    err_valid = 1'b1; err_re = DW'(er); err_im = DW'(ei);
    @(negedge clk);
    err_valid = 1'b0;
    if (stray) begin
      err_valid = 1'b1; err_re = 511; err_im = -512;
    end
    m_adapt(er, ei);
    k = 1;
    while (!done && k < 64) begin
      if (in_ready) busy_seen = 1'b1;
      @(negedge clk);
      err_valid = 1'b0;
      k++;
    end
    period = cyc - t0;
    chk(k == 9, "R8", "done latency in negedges", k, 9);
    chk(in_ready == 1'b1, "R8", "in_ready with done", in_ready, 1);
    if (hold) begin
      in_valid = 1'b0;
      chk(!busy_seen, "R2", "in_ready seen while busy", busy_seen, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done pulse width", done, 0);
  endtask

  initial begin
    longint per;
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(y_valid == 1'b0, "R1", "y_valid after reset", y_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_sym(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5],
              i % 3, (i % 4) == 1, (i % 4) == 2, per);
      if (i == 0) begin
        // R1: only tap 0 real = 0.5 contributes: (200,-100)/2
        chk(y_re == 100, "R1", "first y_re", y_re, 100);
        chk(y_im == -50, "R1", "first y_im", y_im, -50);
      end
      if (i % 3 == 0)
        chk(per <= 20, "R9", "symbol period", per, 20);
    end

    // R5: stray strobe while idle must not update anything
    @(negedge clk);
    err_valid = 1'b1; err_re = -512; err_im = 511;
    @(negedge clk);
    err_valid = 1'b0;
    run_sym(33, -44, 55, -66, 0, 0, 0, 1'b1, 1'b0, per);

    // R7 and R4 saturation: drive coefficients to the top of range
    do_reset();
    for (int i = 0; i < 180; i++)
      run_sym(400, 0, 400, 0, 511, 511, 0, 1'b0, 1'b0, per);
    chk(y_re == 1023, "R4", "saturated y_re", y_re, 1023);
    for (int i = 0; i < 4; i++)
      run_sym(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, per);
    run_sym(64, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, per);
    // c0 clamped at 511: 64*511/512 floors to 63
    chk(y_re == 63, "R7", "probe y_re with saturated coefficient", y_re, 63);
    chk(y_im == 0, "R7", "probe y_im", y_im, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule